// File: doc/BRIEF.md
# Dual-Channel Indirect Register File

This block is the register access path of a two-channel serial controller. A host reaches it through four byte-wide locations: one control port and one data port per channel. Each channel owns sixteen write registers and sixteen read registers. None of them has its own address: they are reached through a pointer held in write register 0 of the channel. The pointer selects a register, a field in the same byte switches to the upper bank ("point-high"), and after the access the pointer falls back so that the next control access lands on register 0 again.

Besides decode and storage, the block keeps two write registers identical across both channels, copies some written values into read registers of the same number, loops modem-control outputs back into the status register, and reports channel commands and external/status events to a neighbouring interrupt controller as one-cycle strobes. Data-port traffic is handed to the data path as strobes; the byte returned on a data-port read comes from that path.

The host uses a single-cycle request (valid, write, address, byte). Read data, and the address-error flag, come back registered one cycle after the request.

Top module: `chreg_top`

## Requirements
- R1: Address 0 is channel A control, 1 is channel A data, 2 is channel B control and 3 is channel B data. Any other address leaves all register state unchanged and raises `host_err` for one cycle; an erroneous read also returns `host_rvalid` with `host_rdata` = 0.
- R2: After reset every register is zero except read register 0 (transmit-ready, bit 2: 0x04), read register 1 (all-sent, bit 0: 0x01) and read register 2 (idle vector 0x06), in both channels.
- R3: The pointer is bits 2..0 of write register 0; bits 5..3 equal to 001 select point-high. A control write reaches write register `sel` without point-high and `8 + sel` with it; with point-high and `sel` = 0 the write is ignored.
- R4: Without point-high a control read returns read register `sel & 3`. With point-high selections 2 and 6 read register 10, 3 and 7 read register 15, 4 reads register 12 and 5 reads register 13.
- R5: A control read with point-high and `sel` = 1 returns 0 and leaves the pointer as it was. A control read with point-high and `sel` = 0 returns 0 and then clears the pointer.
- R6: After a control access whose target is a register other than 0 (including the point-high `sel` = 0 read), bits 4..0 of write register 0 are cleared.
- R7: A write to register 2 or 9 on either channel stores the byte in both channels. Output `mic_byte` carries register 9 of channel B in bits 15..8 and of channel A in bits 7..0.
- R8: A write to register 12, 13 or 15 is also stored into the read register of the same number in that channel; a write to register 2 is stored into read register 2 of both channels. Other write registers have no read copy.
- R9: Writing register 5 with bit 7 set sets bit 3 of read register 0; with bit 1 set it sets bit 5 of read register 0. Both bits stay set. Either bit raises `xs_stb` for one cycle with `xs_chan` = the channel; a write with neither raises nothing.
- R10: A write to register 0 whose bits 5..4 are not 00 raises `cmd_stb` for one cycle with `cmd_chan` and `cmd_code` = bits 5..3 of the byte, and clears write register 0 of that channel entirely.
- R11: `host_rvalid`, `host_rdata` and `host_err` appear in the cycle after the request and only then; writes never raise `host_rvalid`.
- R12: A data-port write raises `dp_wr_stb` with `dp_chan` and `dp_wbyte` one cycle later; a data-port read raises `dp_rd_stb` and returns the `dp_rdata` byte present during the request. Data-port traffic leaves the control pointer untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Request present this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Location select |
| host_wdata | input | 8 | Write byte |
| host_rvalid | output | 1 | Read answer valid |
| host_rdata | output | 8 | Read byte |
| host_err | output | 1 | Request hit no location |
| dp_wr_stb | output | 1 | Data-port write strobe |
| dp_rd_stb | output | 1 | Data-port read strobe |
| dp_chan | output | 1 | Channel of the data-port access |
| dp_wbyte | output | 8 | Byte of the data-port write |
| dp_rdata | input | 8 | Byte the data path supplies for a data-port read |
| cmd_stb | output | 1 | Channel command strobe |
| cmd_chan | output | 1 | Channel that issued the command |
| cmd_code | output | 3 | Command field of the write |
| xs_stb | output | 1 | External/status event strobe |
| xs_chan | output | 1 | Channel of the event |
| mic_byte | output | 16 | Shared register 9 of both channels |

## Verification
Register access is tried with the pointer in each of its three forms: plain selection, aliased selection 4..7, and point-high with every selection. Plain versus aliased reads tell a two-bit read decode from a three-bit one; point-high selections 2/6 and 3/7 tell the irregular remap from a straight "plus 8". Reads following each access reveal whether the pointer fell back, which separates the ignored cases (point-high write with selection 0, read with selection 1) from real accesses. Writes issued on one channel and read back on the other distinguish shared registers from per-channel ones, and writes to unmirrored upper registers show that no read copy is made.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

    localparam int NCH    = 2;
    localparam int NREG   = 16;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(NREG);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    localparam logic [2:0] PH_CODE = 3'b001;

    localparam ridx_t IDX_PTR    = 4'd0;
    localparam ridx_t IDX_SHR_LO = 4'd2;
    localparam ridx_t IDX_MODEM  = 4'd5;
    localparam ridx_t IDX_SHR_HI = 4'd9;
    localparam ridx_t IDX_R10    = 4'd10;
    localparam ridx_t IDX_R12    = 4'd12;
    localparam ridx_t IDX_R13    = 4'd13;
    localparam ridx_t IDX_R15    = 4'd15;

    localparam int ST_TXRDY   = 2;
    localparam int ST_DCD     = 3;
    localparam int ST_CTS     = 5;
    localparam int ST_ALLSENT = 0;
    localparam int MC_DTR     = 7;
    localparam int MC_RTS     = 1;
    localparam byte_t IDLE_VEC = 8'h06;

    typedef struct packed {
        logic [NCH-1:0][NREG-1:0][BYTE_W-1:0] wr;
        logic [NCH-1:0][NREG-1:0][BYTE_W-1:0] rr;
        logic       cmd_stb;
        logic       cmd_chan;
        logic [2:0] cmd_code;
        logic       xs_stb;
        logic       xs_chan;
    } store_t;

    typedef struct packed {
        logic  rvalid;
        byte_t rdata;
        logic  err;
        logic  dp_wr;
        logic  dp_rd;
        logic  dp_ch;
        byte_t dp_byte;
    } host_t;

    function automatic store_t store_reset();
        store_t s;
        s = '0;
        for (int c = 0; c < NCH; c++) begin
            s.rr[c][0][ST_TXRDY]   = 1'b1;
            s.rr[c][1][ST_ALLSENT] = 1'b1;
            s.rr[c][2]             = IDLE_VEC;
        end
        return s;
    endfunction

endpackage

// File: rtl/chreg_ptr_dec.sv
module chreg_ptr_dec
    import chreg_pkg::*;
(
    input  logic [5:0] ptr,
    output ridx_t      wr_idx,
    output logic       wr_ok,
    output ridx_t      rd_idx,
    output logic       rd_ok,
    output logic       rd_clr
);

    logic       ph;
    logic [2:0] sel;

    always_comb begin
        ph     = (ptr[5:3] == PH_CODE);
        sel    = ptr[2:0];
        wr_idx = {1'b0, sel};
        wr_ok  = 1'b1;
        rd_idx = {2'b00, sel[1:0]};
        rd_ok  = 1'b1;
        rd_clr = (sel[1:0] != 2'b00);
        if (ph) begin
            wr_idx = {1'b1, sel};
            wr_ok  = (sel != 3'd0);
            rd_clr = (sel != 3'd1);
            case (sel)
                3'd2, 3'd6: rd_idx = IDX_R10;
                3'd3, 3'd7: rd_idx = IDX_R15;
                3'd4:       rd_idx = IDX_R12;
                3'd5:       rd_idx = IDX_R13;
                default: begin
                    rd_idx = IDX_PTR;
                    rd_ok  = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/chreg_store.sv
module chreg_store
    import chreg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctl_wr,
    input  logic                        ctl_rd,
    input  logic                        ch,
    input  byte_t                       wbyte,
    input  ridx_t                       wr_idx,
    input  logic                        wr_ok,
    input  ridx_t                       rd_idx,
    input  logic                        rd_ok,
    input  logic                        rd_clr,
    output logic [NCH-1:0][BYTE_W-1:0]  ptr_all,
    output byte_t                       rbyte,
    output logic [2*BYTE_W-1:0]         mic,
    output logic                        cmd_stb,
    output logic                        cmd_chan,
    output logic [2:0]                  cmd_code,
    output logic                        xs_stb,
    output logic                        xs_chan
);

    store_t q, d;

    function automatic logic mirrored(ridx_t i);
        return (i == IDX_SHR_LO) || (i == IDX_R12) || (i == IDX_R13) || (i == IDX_R15);
    endfunction

    always_comb begin
        d          = q;
        d.cmd_stb  = 1'b0;
        d.xs_stb   = 1'b0;
        if (ctl_wr && wr_ok) begin
            d.wr[ch][wr_idx] = wbyte;
            if (wr_idx == IDX_SHR_LO || wr_idx == IDX_SHR_HI) begin
                d.wr[~ch][wr_idx] = wbyte;
            end
            if (mirrored(wr_idx)) begin
                d.rr[ch][wr_idx] = wbyte;
            end
            if (wr_idx == IDX_SHR_LO) begin
                d.rr[~ch][IDX_SHR_LO] = wbyte;
            end
            if (wr_idx == IDX_MODEM) begin
                if (wbyte[MC_DTR]) d.rr[ch][0][ST_DCD] = 1'b1;
                if (wbyte[MC_RTS]) d.rr[ch][0][ST_CTS] = 1'b1;
                if (wbyte[MC_DTR] || wbyte[MC_RTS]) begin
                    d.xs_stb  = 1'b1;
                    d.xs_chan = ch;
                end
            end
            if (wr_idx == IDX_PTR && wbyte[5:4] != 2'b00) begin
                d.cmd_stb   = 1'b1;
                d.cmd_chan  = ch;
                d.cmd_code  = wbyte[5:3];
                d.wr[ch][0] = '0;
            end
            if (wr_idx != IDX_PTR) begin
                d.wr[ch][0][4:0] = '0;
            end
        end
        if (ctl_rd && rd_clr) begin
            d.wr[ch][0][4:0] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= store_reset();
        else        q <= d;
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) ptr_all[c] = q.wr[c][0];
        rbyte    = rd_ok ? q.rr[ch][rd_idx] : '0;
        mic      = {q.wr[1][IDX_SHR_HI], q.wr[0][IDX_SHR_HI]};
        cmd_stb  = q.cmd_stb;
        cmd_chan = q.cmd_chan;
        cmd_code = q.cmd_code;
        xs_stb   = q.xs_stb;
        xs_chan  = q.xs_chan;
    end

    AST_PTR_WR_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_ok && wr_idx != IDX_PTR) |=> (q.wr[$past(ch)][0][4:0] == 5'd0)); // R6
    AST_PTR_RD_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && rd_clr) |=> (q.wr[$past(ch)][0][4:0] == 5'd0)); // R6
    AST_SHARED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr[0][IDX_SHR_LO] == q.wr[1][IDX_SHR_LO]) && (q.wr[0][IDX_SHR_HI] == q.wr[1][IDX_SHR_HI])); // R7
    AST_CMD_WIPES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        q.cmd_stb |-> (q.wr[q.cmd_chan][0] == 8'h00)); // R10
    AST_DTR_SETS_DCD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_ok && wr_idx == IDX_MODEM && wbyte[MC_DTR]) |=> q.rr[$past(ch)][0][ST_DCD]); // R9
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.rr[0][0][ST_TXRDY] && q.rr[1][0][ST_TXRDY]); // R2

endmodule

// File: rtl/chreg_host_if.sv
module chreg_host_if
    import chreg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int A_CTRL = 0,
    parameter int A_DATA = 1,
    parameter int B_CTRL = 2,
    parameter int B_DATA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             ctl_rbyte,
    input  byte_t             wdata,
    input  byte_t             dp_rdata,
    output logic              ctl_wr,
    output logic              ctl_rd,
    output logic              acc_ch,
    output host_t             resp
);

    localparam logic [ADDR_W-1:0] AC = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD = ADDR_W'(A_DATA);
    localparam logic [ADDR_W-1:0] BC = ADDR_W'(B_CTRL);
    localparam logic [ADDR_W-1:0] BD = ADDR_W'(B_DATA);

    host_t q, d;
    logic  hit_ctl, hit_dat;

    always_comb begin
        hit_ctl = (addr == AC) || (addr == BC);
        hit_dat = (addr == AD) || (addr == BD);
        acc_ch  = (addr == BC) || (addr == BD);
        ctl_wr  = valid && write && hit_ctl;
        ctl_rd  = valid && !write && hit_ctl;

        d         = '0;
        d.dp_ch   = q.dp_ch;
        d.dp_byte = q.dp_byte;
        if (valid) begin
            d.rvalid = !write;
            d.err    = !(hit_ctl || hit_dat);
            if (!write && hit_ctl) d.rdata = ctl_rbyte;
            if (!write && hit_dat) d.rdata = dp_rdata;
            if (hit_dat) begin
                d.dp_wr = write;
                d.dp_rd = !write;
                d.dp_ch = acc_ch;
                if (write) d.dp_byte = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign resp = q;

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !write) |=> q.rvalid); // R11
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write) |=> !q.rvalid); // R11
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rvalid && q.err) |-> (q.rdata == 8'h00)); // R1

endmodule

// File: rtl/chreg_top.sv
module chreg_top
    import chreg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int A_CTRL = 0,
    parameter int A_DATA = 1,
    parameter int B_CTRL = 2,
    parameter int B_DATA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_rvalid,
    output logic [7:0]        host_rdata,
    output logic              host_err,
    output logic              dp_wr_stb,
    output logic              dp_rd_stb,
    output logic              dp_chan,
    output logic [7:0]        dp_wbyte,
    input  logic [7:0]        dp_rdata,
    output logic              cmd_stb,
    output logic              cmd_chan,
    output logic [2:0]        cmd_code,
    output logic              xs_stb,
    output logic              xs_chan,
    output logic [15:0]       mic_byte
);

    logic                       ctl_wr, ctl_rd, acc_ch;
    host_t                      resp;
    byte_t                      rbyte;
    logic [NCH-1:0][BYTE_W-1:0] ptr_all;
    ridx_t [NCH-1:0]            wr_idx_c, rd_idx_c;
    logic  [NCH-1:0]            wr_ok_c, rd_ok_c, rd_clr_c;

    chreg_host_if #(
        .ADDR_W(ADDR_W), .A_CTRL(A_CTRL), .A_DATA(A_DATA),
        .B_CTRL(B_CTRL), .B_DATA(B_DATA)
    ) i_host (
        .clk(clk), .rst_n(rst_n), .valid(host_valid), .write(host_write),
        .addr(host_addr), .ctl_rbyte(rbyte), .wdata(host_wdata),
        .dp_rdata(dp_rdata), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
        .acc_ch(acc_ch), .resp(resp)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        chreg_ptr_dec i_dec (
            .ptr(ptr_all[c][5:0]),
            .wr_idx(wr_idx_c[c]), .wr_ok(wr_ok_c[c]),
            .rd_idx(rd_idx_c[c]), .rd_ok(rd_ok_c[c]), .rd_clr(rd_clr_c[c])
        );
    end

    chreg_store i_store (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
        .ch(acc_ch), .wbyte(host_wdata),
        .wr_idx(wr_idx_c[acc_ch]), .wr_ok(wr_ok_c[acc_ch]),
        .rd_idx(rd_idx_c[acc_ch]), .rd_ok(rd_ok_c[acc_ch]), .rd_clr(rd_clr_c[acc_ch]),
        .ptr_all(ptr_all), .rbyte(rbyte), .mic(mic_byte),
        .cmd_stb(cmd_stb), .cmd_chan(cmd_chan), .cmd_code(cmd_code),
        .xs_stb(xs_stb), .xs_chan(xs_chan)
    );

    assign host_rvalid = resp.rvalid;
    assign host_rdata  = resp.rdata;
    assign host_err    = resp.err;
    assign dp_wr_stb   = resp.dp_wr;
    assign dp_rd_stb   = resp.dp_rd;
    assign dp_chan     = resp.dp_ch;
    assign dp_wbyte    = resp.dp_byte;

endmodule

// File: tb/test_chreg_top.sv
`timescale 1ns/1ps
module test_chreg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0, dp_rdata = '0;
    logic        host_rvalid, host_err, dp_wr_stb, dp_rd_stb, dp_chan;
    logic [7:0]  host_rdata, dp_wbyte;
    logic        cmd_stb, cmd_chan, xs_stb, xs_chan;
    logic [2:0]  cmd_code;
    logic [15:0] mic_byte;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic       c_rv, c_err, c_dw, c_dr, c_dch, c_cmd, c_cch, c_xs, c_xch;
    logic [7:0] c_rd, c_db;
    logic [2:0] c_ccode;

    localparam logic [3:0] AC = 4'd0, AD = 4'd1, BC = 4'd2, BD = 4'd3;

    always #2.5 clk = ~clk;

    chreg_top i_chreg_top (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .host_err(host_err), .dp_wr_stb(dp_wr_stb),
        .dp_rd_stb(dp_rd_stb), .dp_chan(dp_chan), .dp_wbyte(dp_wbyte),
        .dp_rdata(dp_rdata), .cmd_stb(cmd_stb), .cmd_chan(cmd_chan),
        .cmd_code(cmd_code), .xs_stb(xs_stb), .xs_chan(xs_chan), .mic_byte(mic_byte)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] dat, input logic [7:0] dpi);
        @(negedge clk);
        host_valid = 1'b1; host_write = w; host_addr = a; host_wdata = dat; dp_rdata = dpi;
        @(negedge clk);
        host_valid = 1'b0;
        c_rv = host_rvalid; c_rd = host_rdata; c_err = host_err;
        c_dw = dp_wr_stb; c_dr = dp_rd_stb; c_dch = dp_chan; c_db = dp_wbyte;
        c_cmd = cmd_stb; c_cch = cmd_chan; c_ccode = cmd_code;
        c_xs = xs_stb; c_xch = xs_chan;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        acc(1'b1, a, v, 8'h00);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        acc(1'b0, a, 8'h00, 8'h00);
        chk({tag, " rvalid"}, {15'd0, c_rv}, 16'd1);
        chk(tag, {8'd0, c_rd}, {8'd0, exp});
    endtask

    task automatic t_reset();
        chk("R2 idle outputs", {host_rvalid, cmd_stb, xs_stb, dp_wr_stb, mic_byte[11:0]}, 16'd0);
        rd_chk(AC, 8'h04, "R2 RR0 A reset");
        wr(AC, 8'h01);
        rd_chk(AC, 8'h01, "R2 RR1 A reset");
        wr(BC, 8'h02);
        rd_chk(BC, 8'h06, "R2 RR2 B reset");
    endtask

    task automatic t_pointer();
        rd_chk(AC, 8'h04, "R6 pointer fell after read");
        wr(AC, 8'h05);
        rd_chk(AC, 8'h01, "R4 sel5 aliases to RR1");
        rd_chk(AC, 8'h04, "R6 pointer fell after aliased read");
        wr(AC, 8'h03);
        wr(AC, 8'h11);
        rd_chk(AC, 8'h04, "R6 pointer fell after write to reg3");
        @(negedge clk);
        chk("R11 rvalid only one cycle", {15'd0, host_rvalid}, 16'd0);
    endtask

    task automatic t_point_high();
        wr(AC, 8'h0C); wr(AC, 8'h5A);
        wr(AC, 8'h0C);
        rd_chk(AC, 8'h5A, "R8 WR12 mirrored, R3 point-high write");
        wr(AC, 8'h0F); wr(AC, 8'hC3);
        wr(AC, 8'h0B);
        rd_chk(AC, 8'hC3, "R4 sel3 point-high reads RR15");
        wr(AC, 8'h0D); wr(AC, 8'h66);
        wr(AC, 8'h0D);
        rd_chk(AC, 8'h66, "R8 WR13 mirrored");
        wr(AC, 8'h0A); wr(AC, 8'h99);
        wr(AC, 8'h0E);
        rd_chk(AC, 8'h00, "R8 WR10 not mirrored, R4 sel6 reads RR10");
    endtask

    task automatic t_ignored();
        wr(AC, 8'h09);
        rd_chk(AC, 8'h00, "R5 point-high sel1 read returns 0");
        rd_chk(AC, 8'h00, "R5 point-high sel1 keeps pointer");
        wr(AC, 8'h00);
        rd_chk(AC, 8'h04, "R6 pointer fell after WR9 write");
        wr(AC, 8'h08);
        wr(AC, 8'h77);
        rd_chk(AC, 8'h00, "R3 point-high sel0 write ignored");
        rd_chk(AC, 8'h04, "R5 point-high sel0 read clears pointer");
    endtask

    task automatic t_shared();
        wr(AC, 8'h02); wr(AC, 8'h3C);
        wr(AC, 8'h02);
        rd_chk(AC, 8'h3C, "R8 WR2 mirrored in channel A");
        wr(BC, 8'h02);
        rd_chk(BC, 8'h3C, "R7 WR2 shared into channel B");
        wr(BC, 8'h09); wr(BC, 8'hA5);
        chk("R7 WR9 shared", mic_byte, 16'hA5A5);
        wr(AC, 8'h09); wr(AC, 8'h00);
        chk("R7 WR9 shared clear", mic_byte, 16'h0000);
    endtask

    task automatic t_modem();
        wr(BC, 8'h05); wr(BC, 8'h80);
        chk("R9 DTR event strobe", {14'd0, c_xs, c_xch}, 16'd3);
        rd_chk(BC, 8'h0C, "R9 DTR sets DCD in B");
        wr(AC, 8'h05); wr(AC, 8'h02);
        chk("R9 RTS event strobe", {14'd0, c_xs, c_xch}, 16'd2);
        rd_chk(AC, 8'h24, "R9 RTS sets CTS in A");
        wr(AC, 8'h05); wr(AC, 8'h00);
        chk("R9 no event without bits", {15'd0, c_xs}, 16'd0);
        rd_chk(AC, 8'h24, "R9 status bits sticky");
    endtask

    task automatic t_command();
        wr(AC, 8'h28);
        chk("R10 command A", {11'd0, c_cmd, c_cch, c_ccode}, {11'd0, 1'b1, 1'b0, 3'b101});
        wr(BC, 8'h12);
        chk("R10 command B", {11'd0, c_cmd, c_cch, c_ccode}, {11'd0, 1'b1, 1'b1, 3'b010});
        rd_chk(BC, 8'h0C, "R10 command clears pointer");
        wr(AC, 8'h01);
        chk("R10 no command for pointer write", {15'd0, c_cmd}, 16'd0);
        rd_chk(AC, 8'h01, "R3 plain pointer to RR1");
    endtask

    task automatic t_bad_addr();
        acc(1'b0, 4'd7, 8'h00, 8'h00);
        chk("R1 bad read", {5'd0, c_rv, c_err, 1'b0, c_rd}, {5'd0, 1'b1, 1'b1, 1'b0, 8'h00});
        wr(AC, 8'h01);
        acc(1'b1, 4'd9, 8'h00, 8'h00);
        chk("R1 bad write error", {14'd0, c_rv, c_err}, 16'd1);
        rd_chk(AC, 8'h01, "R1 bad write left pointer");
    endtask

    task automatic t_data();
        acc(1'b1, AD, 8'h41, 8'h00);
        chk("R12 data write strobe", {4'd0, c_rv, c_dw, c_dr, c_dch, c_db}, {4'd0, 4'b0100, 8'h41});
        acc(1'b0, BD, 8'h00, 8'h99);
        chk("R12 data read strobe", {4'd0, c_rv, c_dw, c_dr, c_dch, c_rd}, {4'd0, 4'b1011, 8'h99});
        rd_chk(AC, 8'h24, "R12 data traffic left pointer");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_point_high();
        t_ignored();
        t_shared();
        t_modem();
        t_command();
        t_bad_addr();
        t_data();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule